// File: doc/BRIEF.md
# Direct-Mapped Read/Write Cache with Critical-Word Restart

This block sits between a processor port and a word-wide lower-level memory port. It keeps 16 KB of data as 1024 lines of four 32-bit words. A read that hits returns its word on the next cycle. A read that misses starts a line refill. The refill asks the lower level for the missed word first and releases the processor as soon as that word comes back. It then fetches the other three words of the line in wrap-around order.

Every processor write is passed straight to the lower level. If the addressed line is present and valid, the cached copy is updated in the same cycle the lower level accepts the write. A write that misses leaves the cache contents unchanged. While a refill is still running, every new processor request waits, whichever line it targets.

Top module: `dmc_cache_top`

## Requirements
- R1: A 32-bit byte address is split as follows. Bits [31:14] are the tag, bits [13:4] select one of 1024 lines, and bits [3:2] select one of the four words in the line. Lower-level word addresses are byte address bits [31:2].
- R2: After reset no line is valid, so the first read of any line issues a lower-level read.
- R3: A read hit is accepted in the cycle it is presented and returns the addressed word with `cpu_rsp_valid` high on the next cycle. It causes no lower-level request.
- R4: On a read miss, the first lower-level read carries the word address of the missed word.
- R5: The remaining three reads of a refill follow in wrap-around order within the line (critical+1, +2, +3, modulo 4).
- R6: Early restart. The missed read is accepted in the cycle the first refill response arrives, and that word is returned on the next cycle, before the other three words are requested.
- R7: Any request presented during a refill is held off (`cpu_req_ready` low) until all four words are written. After that the line is valid and hits.
- R8: A miss on a line that holds another tag replaces it, so the old tag then misses.
- R9: Every processor write appears on the lower-level port as a write with the word address and data. It is accepted in the same cycle the lower level accepts it.
- R10: A write hit updates the cached word, so a later read hit returns the new data without a lower-level read.
- R11: A write miss does not allocate, so a following read of that line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present, held until accepted |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_req_ready | output | 1 | Request accepted this cycle |
| cpu_rsp_valid | output | 1 | Read data valid |
| cpu_rsp_rdata | output | 32 | Read data |
| mem_req_valid | output | 1 | Lower-level request present |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 30 | Lower-level word address |
| mem_req_wdata | output | 32 | Lower-level write data |
| mem_req_ready | input | 1 | Lower level accepts request |
| mem_rsp_valid | input | 1 | One read word returned |
| mem_rsp_data | input | 32 | Returned word |

## Verification
Two events can meet in one cycle. The first is the arrival of the critical refill word, which releases the stalled processor read. The second is the refill engine going on to request the next wrap-around word, while a second processor request is already waiting. The bench provokes this by presenting a hit to another line right after a miss returns. It judges the overlap by counting lower-level reads: exactly one when the missed read is accepted, and all four when the waiting hit is accepted. It then compares the order of all four reads with the wrap-around sequence.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int ADDR_W         = 32;
    localparam int DATA_W         = 32;
    localparam int WORDS_PER_LINE = 4;
    localparam int LINES          = 1024;
    localparam int LINE_BYTES     = WORDS_PER_LINE * DATA_W / 8;
    localparam int OFS_W          = $clog2(LINE_BYTES);
    localparam int WSEL_W         = $clog2(WORDS_PER_LINE);
    localparam int BSEL_W         = OFS_W - WSEL_W;
    localparam int IDX_W          = $clog2(LINES);
    localparam int TAG_W          = ADDR_W - IDX_W - OFS_W;
    localparam int WADDR_W        = ADDR_W - BSEL_W;

    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [WSEL_W-1:0]  wsel_t;
    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [WADDR_W-1:0] waddr_t;

    typedef struct packed {
        tag_t               tag;
        idx_t               idx;
        wsel_t              wsel;
        logic [BSEL_W-1:0]  bsel;
    } addr_fields_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT
    } fill_state_t;

    localparam wsel_t LAST_BEAT = wsel_t'(WORDS_PER_LINE - 1);

    function automatic addr_fields_t split_addr(input logic [ADDR_W-1:0] a);
        return addr_fields_t'(a);
    endfunction

    function automatic waddr_t join_waddr(input tag_t t, input idx_t i, input wsel_t w);
        return {t, i, w};
    endfunction
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store
    import dmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t rd_idx,
    input  tag_t rd_tag,
    output logic hit,
    input  logic inval_en,
    input  idx_t inval_idx,
    input  logic set_en,
    input  idx_t set_idx,
    input  tag_t set_tag
);
    logic [LINES-1:0] valid_q;
    tag_t             tag_mem [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (inval_en) valid_q[inval_idx] <= 1'b0;
            if (set_en)   valid_q[set_idx]   <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) tag_mem[set_idx] <= set_tag;
    end

    assign hit = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);

    // R8
    set_inval_excl_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !inval_en);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
(
    input  logic  clk,
    input  idx_t  rd_idx,
    input  wsel_t rd_wsel,
    output word_t rd_data,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  wsel_t wr_wsel,
    input  word_t wr_data
);
    word_t lane_rd [WORDS_PER_LINE];

    for (genvar g = 0; g < WORDS_PER_LINE; g++) begin : g_lane
        word_t lane_mem [LINES];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_wsel == wsel_t'(g))) lane_mem[wr_idx] <= wr_data;
        end
        assign lane_rd[g] = lane_mem[rd_idx];
    end

    assign rd_data = lane_rd[rd_wsel];
endmodule

// File: rtl/dmc_refill_ctrl.sv
module dmc_refill_ctrl
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  word_t             cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_rsp_valid,
    output word_t             cpu_rsp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output waddr_t            mem_req_addr,
    output word_t             mem_req_wdata,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  word_t             mem_rsp_data,
    input  logic              hit,
    input  word_t             rd_data,
    output logic              wr_en,
    output idx_t              wr_idx,
    output wsel_t             wr_wsel,
    output word_t             wr_data,
    output logic              inval_en,
    output logic              set_en,
    output idx_t              fill_idx_o,
    output tag_t              fill_tag_o
);
    fill_state_t  state_q;
    tag_t         fill_tag_q;
    idx_t         fill_idx_q;
    wsel_t        crit_wsel_q;
    wsel_t        beat_q;
    wsel_t        cur_wsel;
    addr_fields_t f;
    logic         rd_acc;
    logic         unused_bsel;

    assign f           = split_addr(cpu_req_addr);
    assign unused_bsel = ^f.bsel;
    assign cur_wsel    = crit_wsel_q + beat_q;
    assign fill_idx_o  = fill_idx_q;
    assign fill_tag_o  = fill_tag_q;

    always_comb begin
        cpu_req_ready = 1'b0;
        rd_acc        = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        wr_en         = 1'b0;
        wr_idx        = f.idx;
        wr_wsel       = f.wsel;
        wr_data       = cpu_req_wdata;
        inval_en      = 1'b0;
        set_en        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    if (cpu_req_write) begin
                        mem_req_valid = 1'b1;
                        mem_req_write = 1'b1;
                        mem_req_addr  = cpu_req_addr[ADDR_W-1:BSEL_W];
                        mem_req_wdata = cpu_req_wdata;
                        cpu_req_ready = mem_req_ready;
                        wr_en         = mem_req_ready && hit;
                    end else begin
                        cpu_req_ready = hit;
                        rd_acc        = hit;
                        inval_en      = !hit;
                    end
                end
            end
            ST_ISSUE: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = join_waddr(fill_tag_q, fill_idx_q, cur_wsel);
            end
            ST_AWAIT: begin
                wr_idx  = fill_idx_q;
                wr_wsel = cur_wsel;
                wr_data = mem_rsp_data;
                if (mem_rsp_valid) begin
                    wr_en = 1'b1;
                    if (beat_q == '0) begin
                        cpu_req_ready = 1'b1;
                        rd_acc        = 1'b1;
                    end
                    if (beat_q == LAST_BEAT) set_en = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            fill_tag_q  <= '0;
            fill_idx_q  <= '0;
            crit_wsel_q <= '0;
            beat_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req_valid && !cpu_req_write && !hit) begin
                        state_q     <= ST_ISSUE;
                        fill_tag_q  <= f.tag;
                        fill_idx_q  <= f.idx;
                        crit_wsel_q <= f.wsel;
                        beat_q      <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) state_q <= ST_AWAIT;
                end
                ST_AWAIT: begin
                    if (mem_rsp_valid) begin
                        beat_q  <= beat_q + 1'b1;
                        state_q <= (beat_q == LAST_BEAT) ? ST_IDLE : ST_ISSUE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cpu_rsp_valid <= 1'b0;
        else     cpu_rsp_valid <= rd_acc;
    end

    always_ff @(posedge clk) begin
        if (rd_acc) cpu_rsp_rdata <= (state_q == ST_AWAIT) ? mem_rsp_data : rd_data;
    end

    // R6
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_req_valid && cpu_req_ready && !cpu_req_write |=> cpu_rsp_valid);

    // R3
    hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE && cpu_req_valid && !cpu_req_write && hit |-> !mem_req_valid);

    // R7
    fill_stall_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != ST_IDLE && beat_q != '0 |-> !cpu_req_ready);

    // R9
    write_through_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_req_valid && cpu_req_write && cpu_req_ready |-> mem_req_valid && mem_req_write && mem_req_ready);
endmodule

// File: rtl/dmc_cache_top.sv
module dmc_cache_top
    import dmc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_req_valid,
    input  logic                  cpu_req_write,
    input  logic [ADDR_W-1:0]     cpu_req_addr,
    input  logic [DATA_W-1:0]     cpu_req_wdata,
    output logic                  cpu_req_ready,
    output logic                  cpu_rsp_valid,
    output logic [DATA_W-1:0]     cpu_rsp_rdata,
    output logic                  mem_req_valid,
    output logic                  mem_req_write,
    output logic [WADDR_W-1:0]    mem_req_addr,
    output logic [DATA_W-1:0]     mem_req_wdata,
    input  logic                  mem_req_ready,
    input  logic                  mem_rsp_valid,
    input  logic [DATA_W-1:0]     mem_rsp_data
);
    addr_fields_t f;
    logic  hit;
    word_t rd_data;
    logic  wr_en;
    idx_t  wr_idx;
    wsel_t wr_wsel;
    word_t wr_data;
    logic  inval_en;
    logic  set_en;
    idx_t  fill_idx;
    tag_t  fill_tag;

    assign f = split_addr(cpu_req_addr);

    dmc_tag_store u_tags (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (f.idx),
        .rd_tag    (f.tag),
        .hit       (hit),
        .inval_en  (inval_en),
        .inval_idx (f.idx),
        .set_en    (set_en),
        .set_idx   (fill_idx),
        .set_tag   (fill_tag)
    );

    dmc_data_store u_data (
        .clk     (clk),
        .rd_idx  (f.idx),
        .rd_wsel (f.wsel),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_wsel (wr_wsel),
        .wr_data (wr_data)
    );

    dmc_refill_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .cpu_req_addr  (cpu_req_addr),
        .cpu_req_wdata (cpu_req_wdata),
        .cpu_req_ready (cpu_req_ready),
        .cpu_rsp_valid (cpu_rsp_valid),
        .cpu_rsp_rdata (cpu_rsp_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .hit           (hit),
        .rd_data       (rd_data),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_wsel       (wr_wsel),
        .wr_data       (wr_data),
        .inval_en      (inval_en),
        .set_en        (set_en),
        .fill_idx_o    (fill_idx),
        .fill_tag_o    (fill_tag)
    );
endmodule

// File: tb/dmc_cache_top_tb_top.sv
module dmc_cache_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_write = 1'b0;
    logic [31:0] cpu_req_addr  = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_req_ready;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_rdata;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [29:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data  = '0;

    always #5 clk = ~clk;

    dmc_cache_top dut_i (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int last_acc_rd = 0;

    logic [31:0] shadow [logic [29:0]];
    logic [29:0] rd_log [$];
    logic [61:0] wr_log [$];
    logic [31:0] exp_q  [$];
    string       exp_tag_q [$];

    function automatic logic [31:0] model_rd(input logic [29:0] wa);
        if (shadow.exists(wa)) return shadow[wa];
        return {2'b10, wa} ^ 32'h3C3C_0F0F;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lower-level memory model: ready pattern, fixed read latency
    int unsigned cyc = 0;
    logic        pend = 1'b0;
    int          lat_cnt = 0;
    logic [29:0] pend_wa = '0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            pend = 1'b0;
        end else begin
            mem_req_ready <= (cyc % 3) != 1;
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    shadow[mem_req_addr] = mem_req_wdata;
                    wr_log.push_back({mem_req_addr, mem_req_wdata});
                end else begin
                    pend = 1'b1;
                    lat_cnt = 2;
                    pend_wa = mem_req_addr;
                    rd_log.push_back(mem_req_addr);
                end
            end else if (pend) begin
                if (lat_cnt == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= model_rd(pend_wa);
                    pend = 1'b0;
                end else begin
                    lat_cnt--;
                end
            end
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && cpu_rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", cpu_rsp_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = exp_tag_q.pop_front();
                check(cpu_rsp_rdata == e, t, cpu_rsp_rdata, e);
            end
        end
    end

    task automatic cpu_read(input logic [31:0] a, input bit exp_hit, input bit wait_fill, input string req);
        int n0;
        int n_acc;
        n0 = rd_log.size();
        cpu_req_valid = 1'b1;
        cpu_req_write = 1'b0;
        cpu_req_addr  = a;
        #1;
        while (!cpu_req_ready) begin
            @(negedge clk);
            #1;
        end
        n_acc = rd_log.size();
        last_acc_rd = n_acc;
        exp_q.push_back(model_rd(a[31:2]));
        exp_tag_q.push_back(req);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        // R3 / R6: data one cycle after acceptance
        check(cpu_rsp_valid, exp_hit ? "R3" : "R6", 32'(cpu_rsp_valid), 32'd1);
        if (exp_hit) begin
            check(rd_log.size() == n_acc, "R3", 32'(rd_log.size()), 32'(n_acc));
        end else begin
            // R6: only the critical word requested at release
            check(n_acc == n0 + 1, "R6", 32'(n_acc), 32'(n0 + 1));
        end
        if (wait_fill) repeat (14) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, input string req);
        int w0;
        w0 = wr_log.size();
        cpu_req_valid = 1'b1;
        cpu_req_write = 1'b1;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        #1;
        while (!cpu_req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        cpu_req_write = 1'b0;
        check(wr_log.size() == w0 + 1, req, 32'(wr_log.size()), 32'(w0 + 1));
        if (wr_log.size() > w0)
            check(wr_log[w0] == {a[31:2], d}, req, wr_log[w0][31:0], d);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_order(input int n0, input logic [31:0] a, input string req);
        for (int k = 0; k < 4; k++) begin
            logic [29:0] e;
            e = {a[31:4], 2'(a[3:2] + k)};
            if (rd_log.size() > n0 + k)
                check(rd_log[n0 + k] == e, req, 32'(rd_log[n0 + k]), 32'(e));
            else
                check(1'b0, req, 32'h0, 32'(e));
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: quiet after reset
        check(!cpu_rsp_valid, "R2", 32'(cpu_rsp_valid), 32'd0);
        check(!mem_req_valid, "R2", 32'(mem_req_valid), 32'd0);

        // R1 R2 R4 R5: cold miss on word 1 of line 1
        n0 = rd_log.size();
        cpu_read(32'h0000_0014, 1'b0, 1'b1, "R2");
        check_order(n0, 32'h0000_0014, "R4");
        // R1 R3: word 3 of the same line hits
        cpu_read(32'h0000_001C, 1'b1, 1'b1, "R1");
        // R5: another cold line
        n0 = rd_log.size();
        cpu_read(32'h0000_0034, 1'b0, 1'b1, "R4");
        check_order(n0, 32'h0000_0034, "R5");
        // R8: conflicting tag on line 1
        n0 = rd_log.size();
        cpu_read(32'h0000_8014, 1'b0, 1'b1, "R8");
        check_order(n0, 32'h0000_8014, "R8");
        cpu_read(32'h0000_0014, 1'b0, 1'b1, "R8");
        // R7: hit waiting behind an ongoing refill
        n0 = rd_log.size();
        cpu_read(32'h0000_0128, 1'b0, 1'b0, "R6");
        cpu_read(32'h0000_0034, 1'b1, 1'b1, "R7");
        check(last_acc_rd == n0 + 4, "R7", 32'(last_acc_rd), 32'(n0 + 4));
        check_order(n0, 32'h0000_0128, "R5");
        cpu_read(32'h0000_0120, 1'b1, 1'b1, "R7");
        // R9 R10: write hit then read hit
        cpu_write(32'h0000_0018, 32'hCAFE_0018, "R9");
        cpu_read(32'h0000_0018, 1'b1, 1'b1, "R10");
        // R9 R11: write miss then read miss
        cpu_write(32'h0000_4000, 32'hBEEF_4000, "R9");
        cpu_read(32'h0000_4000, 1'b0, 1'b1, "R11");
        // R5: wrap from word 3 and from word 0
        n0 = rd_log.size();
        cpu_read(32'h0000_020C, 1'b0, 1'b1, "R5");
        check_order(n0, 32'h0000_020C, "R5");
        n0 = rd_log.size();
        cpu_read(32'h0000_0300, 1'b0, 1'b1, "R5");
        check_order(n0, 32'h0000_0300, "R5");
        cpu_read(32'h0000_030C, 1'b1, 1'b1, "R1");
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule